// File: doc/BRIEF.md
# Programmable Sinc Decimation Filter

This block turns a one-bit oversampled stream into multi-bit signed results. Each accepted input bit counts as +1 or -1. It feeds a chain of integrators that run at the input rate. At the end of every decimation period, differentiators that run at the output rate reduce the integrator value to one filtered result. The filter order can be changed at run time:

- a first-order box filter;
- a second-order filter;
- a third-order filter;
- a fast-settling second-order variant whose period is twice the programmed oversampling ratio.

Results leave on a 32-bit port with a one-cycle ready pulse. They come either at full 32-bit precision or shifted and clamped to a 16-bit range.

Several copies of the block can share the same decimation phase. In master mode a copy starts when a common master enable goes high. In PWM mode a copy starts on an external sync pulse, and each later pulse restarts it. After every start, the results that come before the filter has settled are withheld, so a ready pulse always marks settled data. The integrators and differentiators are 32 bits wide and wrap in two's complement.

Top module: `sinc_decim`

## Requirements
- R1: `cfg_kind` selects the filter: 0 = first order, 1 = second order, 2 = fast second order, 3 = third order. An input bit of 1 counts as +1 and 0 counts as -1. With a settled constant input of all ones (all zeros) the result is +P^N (-P^N), where P is the effective period and N the order. For the first order filter the magnitude never exceeds P.
- R2: The oversampling ratio is `cfg_osr_m1`+1, which covers 1 to 256. One decimation period is that many accepted samples. A sample is accepted only in a cycle with `bit_vld` high, and cycles with `bit_vld` low are ignored.
- R3: The fast variant (kind 2) is a second-order filter whose period is 2×(`cfg_osr_m1`+1) accepted samples.
- R4: After every start or restart, the first N-1 results are computed but not flagged ready, and `dout` keeps its old value for them.
- R5: `dout_rdy` is a one-cycle pulse in the cycle after the clock edge that takes the last sample of a period. `dout` changes only together with `dout_rdy` and holds its value otherwise.
- R6: With `cfg_wide`=1, `dout` is the full 32-bit filter result.
- R7: With `cfg_wide`=0, the result is arithmetically shifted right by `cfg_shift` (0 to 31), clamped to the range -32768 to 32767, and sign-extended into `dout`.
- R8: While `cfg_en` is 0, all filter state and the period counter are held cleared, samples are ignored and no `dout_rdy` occurs. `dout` keeps its last value.
- R9: With `sync_sel`=0 the filter runs only while `cfg_en` and `master_en` are both 1. The cycle in which that condition becomes true clears all state, and a sample in that cycle is discarded.
- R10: With `sync_sel`=1 the filter stays idle until a `pwm_sync` pulse arrives while `cfg_en` is 1. Every such pulse clears the integrators, the differentiators and the period counter in that cycle, and a sample in that cycle is discarded.
- R11: After reset, `dout` is 0 and `dout_rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable for this filter |
| cfg_kind | input | 2 | Filter type (R1 encoding) |
| cfg_osr_m1 | input | 8 | Oversampling ratio minus one |
| cfg_wide | input | 1 | 1: 32-bit result, 0: 16-bit clamped result |
| cfg_shift | input | 5 | Right shift applied in 16-bit mode |
| sync_sel | input | 1 | 0: start on master enable, 1: start on PWM sync pulse |
| master_en | input | 1 | Shared master enable |
| pwm_sync | input | 1 | Shared phase sync pulse |
| bit_vld | input | 1 | Input sample strobe |
| bit_in | input | 1 | Modulator bit |
| dout | output | 32 | Filter result |
| dout_rdy | output | 1 | One-cycle result ready pulse |

## Verification
The assertions assume that the type, ratio, width and shift settings stay still while the filter runs. Several checks compare `dout` with settings sampled one cycle earlier, so a setting that changes inside a period would make a correct result look wrong. The bench therefore changes settings only while `cfg_en` or the master enable is low. It also holds `bit_vld` low in every start or sync cycle, so no check depends on which side of a restart a discarded sample falls. Sync pulses are kept one cycle wide, as the restart properties expect.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  // accumulator and narrow result widths
  localparam int ACC_W    = 32;
  localparam int NARROW_W = 16;
  // highest filter order supported
  localparam int MAX_ORD  = 3;

  typedef enum logic [1:0] {
    K_SINC1 = 2'd0,
    K_SINC2 = 2'd1,
    K_FAST  = 2'd2,
    K_SINC3 = 2'd3
  } kind_e;

  // filter order belonging to a type
  function automatic logic [1:0] order_of(kind_e k);
    case (k)
      K_SINC1: return 2'd1;
      K_SINC3: return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  // number of withheld results after a start
  function automatic logic [1:0] hold_count(kind_e k);
    return order_of(k) - 2'd1;
  endfunction

  // effective period minus one, in accepted samples
  function automatic logic [8:0] period_m1(kind_e k, logic [7:0] osr_m1);
    if (k == K_FAST) return {osr_m1, 1'b1};
    return {1'b0, osr_m1};
  endfunction

  // output formatting: full width, or shift then clamp to the narrow range
  function automatic logic [ACC_W-1:0] fmt_out(logic [ACC_W-1:0] v,
                                               logic wide,
                                               logic [4:0] sh);
    logic signed [ACC_W-1:0] s;
    logic signed [ACC_W-1:0] hi;
    logic signed [ACC_W-1:0] lo;
    hi = $signed({{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}});
    lo = ~hi;
    s  = $signed(v) >>> sh;
    if (wide)    return v;
    if (s > hi)  return hi;
    if (s < lo)  return lo;
    return s;
  endfunction

endpackage

// File: rtl/sinc_ctrl.sv
module sinc_ctrl
  import sinc_pkg::*;
#(
  parameter int OSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  kind_e            kind,
  input  logic [OSR_W-1:0] osr_m1,
  input  logic             sync_sel,
  input  logic             master_en,
  input  logic             pwm_sync,
  input  logic             bit_vld,
  output logic             clr,
  output logic             take,
  output logic             dec_evt,
  output logic             settled
);

  localparam int CNT_W = OSR_W + 1;

  logic             armed_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sc_q;

  logic             run_now;
  logic             restart;
  logic [CNT_W-1:0] last_idx;
  logic             period_end;

  // run condition depends on the chosen start source
  assign run_now  = cfg_en & (sync_sel ? armed_q : master_en);
  // master mode restarts on the rising run condition, PWM mode on every pulse
  assign restart  = sync_sel ? (cfg_en & pwm_sync) : (run_now & ~run_q);
  assign clr      = ~run_now | restart;
  assign take     = run_now & ~restart & bit_vld;

  assign last_idx   = CNT_W'(period_m1(kind, 8'(osr_m1)));
  assign period_end = (cnt_q == last_idx);
  assign dec_evt    = take & period_end;
  assign settled    = (sc_q >= hold_count(kind));

  // PWM arming: set by a pulse while enabled, dropped when disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (!cfg_en || !sync_sel) begin
      armed_q <= 1'b0;
    end else if (pwm_sync) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_now;
    end
  end

  // decimation phase counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (take) begin
      if (period_end) cnt_q <= '0;
      else            cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // settling counter: counts withheld results after a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (clr) begin
      sc_q <= '0;
    end else if (dec_evt && !settled) begin
      sc_q <= sc_q + 2'd1;
    end
  end

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ
  import sinc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             bit_in,
  input  logic [1:0]       order,
  output logic [ACC_W-1:0] integ_out
);

  // next-state value of each integrator, chained through the stages
  logic [MAX_ORD-1:0][ACC_W-1:0] acc_d;

  for (genvar k = 0; k < MAX_ORD; k++) begin : g_st
    logic [ACC_W-1:0] q;

    if (k == 0) begin : g_first
      assign acc_d[k] = q + (bit_in ? ACC_W'(1) : {ACC_W{1'b1}});
    end else begin : g_rest
      assign acc_d[k] = q + acc_d[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (clr) begin
        q <= '0;
      end else if (take) begin
        q <= acc_d[k];
      end
    end
  end

  // tap the integrator matching the order, including this cycle's sample
  always_comb begin
    case (order)
      2'd1:    integ_out = acc_d[0];
      2'd2:    integ_out = acc_d[1];
      default: integ_out = acc_d[MAX_ORD-1];
    endcase
  end

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
  import sinc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dec_evt,
  input  logic [ACC_W-1:0] din,
  input  logic [1:0]       order,
  output logic [ACC_W-1:0] dres
);

  // c[k] is the input of differentiator k, c[k+1] its output
  logic [MAX_ORD:0][ACC_W-1:0] c;

  assign c[0] = din;

  for (genvar k = 0; k < MAX_ORD; k++) begin : g_df
    logic [ACC_W-1:0] z;

    assign c[k+1] = c[k] - z;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        z <= '0;
      end else if (clr) begin
        z <= '0;
      end else if (dec_evt) begin
        z <= c[k];
      end
    end
  end

  always_comb begin
    case (order)
      2'd1:    dres = c[1];
      2'd2:    dres = c[2];
      default: dres = c[MAX_ORD];
    endcase
  end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int OSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_kind,
  input  logic [OSR_W-1:0] cfg_osr_m1,
  input  logic             cfg_wide,
  input  logic [4:0]       cfg_shift,
  input  logic             sync_sel,
  input  logic             master_en,
  input  logic             pwm_sync,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [31:0]      dout,
  output logic             dout_rdy
);

  // named internal events, visible to the bound checker
  logic             clr;
  logic             take;
  logic             dec_evt;
  logic             settled;
  kind_e            kind;
  logic [1:0]       order;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] dres;
  logic [ACC_W-1:0] dout_q;
  logic             rdy_q;

  assign kind  = kind_e'(cfg_kind);
  assign order = order_of(kind);

  sinc_ctrl #(.OSR_W(OSR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .kind      (kind),
    .osr_m1    (cfg_osr_m1),
    .sync_sel  (sync_sel),
    .master_en (master_en),
    .pwm_sync  (pwm_sync),
    .bit_vld   (bit_vld),
    .clr       (clr),
    .take      (take),
    .dec_evt   (dec_evt),
    .settled   (settled)
  );

  sinc_integ u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .take      (take),
    .bit_in    (bit_in),
    .order     (order),
    .integ_out (integ_out)
  );

  sinc_comb u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .dec_evt (dec_evt),
    .din     (integ_out),
    .order   (order),
    .dres    (dres)
  );

  // result register: loads only for settled results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= dec_evt & settled;
      if (dec_evt && settled) begin
        dout_q <= fmt_out(dres, cfg_wide, cfg_shift);
      end
    end
  end

  assign dout     = dout_q;
  assign dout_rdy = rdy_q;

endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int OSR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [1:0]       cfg_kind,
  input logic [OSR_W-1:0] cfg_osr_m1,
  input logic             cfg_wide,
  input logic             sync_sel,
  input logic             master_en,
  input logic             pwm_sync,
  input logic             bit_vld,
  input logic [31:0]      dout,
  input logic             dout_rdy,
  input logic             dec_evt
);

  logic signed [31:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= 32'sd1;
    else        lim_q <= $signed({{(32-OSR_W){1'b0}}, cfg_osr_m1}) + 32'sd1;
  end

  // R2
  vld_before_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_rdy |-> $past(bit_vld));

  // R5
  rdy_from_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_rdy |-> $past(dec_evt));

  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_rdy |-> $stable(dout));

  // R8
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !dout_rdy);

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_rdy && !$past(sync_sel)) |-> $past(master_en));

  // R10
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel && cfg_en && pwm_sync) |=> !dout_rdy);

  // R7
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_rdy && !$past(cfg_wide)) |->
      ($countones(dout[31:15]) == 0 || $countones(dout[31:15]) == 17));

  // R1
  box_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_rdy && $past(cfg_kind) == 2'd0 && $past(cfg_wide)) |->
      ($signed(dout) <= lim_q && $signed(dout) >= -lim_q));

endmodule

bind sinc_decim sinc_decim_chk #(.OSR_W(OSR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_kind   (cfg_kind),
  .cfg_osr_m1 (cfg_osr_m1),
  .cfg_wide   (cfg_wide),
  .sync_sel   (sync_sel),
  .master_en  (master_en),
  .pwm_sync   (pwm_sync),
  .bit_vld    (bit_vld),
  .dout       (dout),
  .dout_rdy   (dout_rdy),
  .dec_evt    (dec_evt)
);

// File: tb/sinc_decim_bench.sv
module sinc_decim_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_kind = 2'd0;
  logic [7:0]  cfg_osr_m1 = 8'd0;
  logic        cfg_wide = 1'b1;
  logic [4:0]  cfg_shift = 5'd0;
  logic        sync_sel = 1'b0;
  logic        master_en = 1'b0;
  logic        pwm_sync = 1'b0;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic [31:0] dout;
  logic        dout_rdy;

  always #(CLK_P/2) clk = ~clk;

  sinc_decim u_sinc_decim (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_kind(cfg_kind),
    .cfg_osr_m1(cfg_osr_m1), .cfg_wide(cfg_wide), .cfg_shift(cfg_shift),
    .sync_sel(sync_sel), .master_en(master_en), .pwm_sync(pwm_sync),
    .bit_vld(bit_vld), .bit_in(bit_in), .dout(dout), .dout_rdy(dout_rdy)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    rdy_seen = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int q[$];
  int m_i[3];
  int m_z[3];
  int m_cnt;
  int m_sc;
  bit m_on;
  logic [15:0] lf = 16'hACE1;

  function automatic int ord_m(int k);
    if (k == 0) return 1;
    if (k == 3) return 3;
    return 2;
  endfunction

  function automatic int per_m(int k, int m1);
    return (k == 2) ? 2 * (m1 + 1) : (m1 + 1);
  endfunction

  function automatic int shape(int v, bit w, int sh);
    int s;
    if (w) return v;
    s = v >>> sh;
    if (s > 32767)  return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // checks every ready pulse against the model queue
  always @(negedge clk) begin
    int e;
    if (rst_n && dout_rdy && !done) begin
      rdy_seen++;
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected ready, actual=%0d expected=none",
                 cur_req, $signed(dout));
      end else begin
        e = q.pop_front();
        if (dout !== 32'(e)) begin
          n_bad++;
          $display("FAIL %s: actual=%0d expected=%0d", cur_req, $signed(dout), e);
        end
      end
    end
  end

  task automatic m_clear();
    for (int k = 0; k < 3; k++) begin
      m_i[k] = 0;
      m_z[k] = 0;
    end
    m_cnt = 0;
    m_sc  = 0;
  endtask

  task automatic idle(int n);
    bit_vld = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive one accepted sample and advance the model
  task automatic feed(bit b);
    int v, ord, y, t, r;
    bit_in  = b;
    bit_vld = 1'b1;
    if (m_on) begin
      ord = ord_m(int'(cfg_kind));
      v = b ? 1 : -1;
      m_i[0] += v;
      m_i[1] += m_i[0];
      m_i[2] += m_i[1];
      m_cnt++;
      if (m_cnt == per_m(int'(cfg_kind), int'(cfg_osr_m1))) begin
        m_cnt = 0;
        y = m_i[ord-1];
        r = 0;
        for (int k = 0; k < 3; k++) begin
          t = y - m_z[k];
          m_z[k] = y;
          y = t;
          if (k == ord - 1) r = t;
        end
        if (m_sc >= ord - 1) q.push_back(shape(r, cfg_wide, int'(cfg_shift)));
        else m_sc++;
      end
    end
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
  endtask

  task automatic feed_n(bit b, int n);
    for (int i = 0; i < n; i++) feed(b);
  endtask

  task automatic start_master(int k, int m1, bit w, int sh);
    cfg_en = 1'b0; master_en = 1'b0; sync_sel = 1'b0;
    idle(1);
    cfg_kind = 2'(k); cfg_osr_m1 = 8'(m1); cfg_wide = w; cfg_shift = 5'(sh);
    cfg_en = 1'b1; master_en = 1'b1;
    m_clear();
    m_on = 1;
    idle(1);
  endtask

  task automatic drain(string req);
    idle(4);
    chk({req, " pending results"}, q.size(), 0);
  endtask

  task automatic t_reset();
    cur_req = "R11";
    chk("R11 dout after reset", int'(dout), 0);
    chk("R11 ready after reset", int'(dout_rdy), 0);
  endtask

  task automatic t_box();
    int r0;
    cur_req = "R1";
    start_master(0, 15, 1, 0);
    r0 = rdy_seen;
    feed_n(1'b1, 48);
    idle(2);
    chk("R1 box all ones", $signed(dout), 16);
    chk("R2 box period count", rdy_seen - r0, 3);
    for (int i = 0; i < 32; i++) begin
      feed(i[1]);
      if (i % 5 == 0) idle(2);
    end
    drain("R2");
  endtask

  task automatic t_second();
    int r0;
    cur_req = "R4";
    start_master(1, 7, 1, 0);
    r0 = rdy_seen;
    feed_n(1'b0, 40);
    idle(2);
    chk("R1 second order all zeros", $signed(dout), -64);
    chk("R4 second order withholds one", rdy_seen - r0, 4);
    drain("R4");
  endtask

  task automatic t_third_max();
    int r0;
    cur_req = "R2";
    start_master(3, 255, 1, 0);
    r0 = rdy_seen;
    feed_n(1'b1, 1024);
    idle(2);
    chk("R2 third order ratio 256", $signed(dout), 16777216);
    chk("R4 third order withholds two", rdy_seen - r0, 2);
    drain("R2");
  endtask

  task automatic t_fast();
    int r0;
    cur_req = "R3";
    start_master(2, 3, 1, 0);
    r0 = rdy_seen;
    feed_n(1'b1, 40);
    idle(2);
    chk("R3 fast doubled period value", $signed(dout), 64);
    chk("R3 fast period count", rdy_seen - r0, 4);
    drain("R3");
  endtask

  task automatic t_narrow();
    cur_req = "R7";
    start_master(3, 63, 0, 0);
    feed_n(1'b1, 256);
    idle(2);
    chk("R7 clamp high", int'(dout), 32767);
    start_master(3, 63, 0, 4);
    feed_n(1'b1, 256);
    idle(2);
    chk("R7 shift by 4", int'(dout), 16384);
    start_master(3, 63, 0, 0);
    feed_n(1'b0, 256);
    idle(2);
    chk("R7 clamp low sign-extended", int'(dout), 32'hFFFF8000);
    drain("R7");
  endtask

  task automatic t_mixed();
    cur_req = "R6";
    start_master(3, 9, 1, 0);
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      feed(lf[0]);
      if (lf[3] && lf[7]) idle(1);
    end
    drain("R6");
  endtask

  task automatic t_unit();
    int r0;
    cur_req = "R2";
    start_master(0, 0, 1, 0);
    r0 = rdy_seen;
    for (int i = 0; i < 8; i++) feed(i[0]);
    idle(2);
    chk("R2 ratio one result per sample", rdy_seen - r0, 8);
    drain("R2");
  endtask

  task automatic t_disable();
    int r0;
    int d0;
    cur_req = "R8";
    start_master(1, 3, 1, 0);
    feed_n(1'b1, 12);
    idle(2);
    cfg_en = 1'b0;
    m_on = 0;
    idle(1);
    r0 = rdy_seen;
    d0 = int'(dout);
    feed_n(1'b0, 40);
    idle(2);
    chk("R8 disabled gives no ready", rdy_seen - r0, 0);
    chk("R8 dout held while disabled", int'(dout), d0);
    cur_req = "R9";
    cfg_en = 1'b1;
    master_en = 1'b0;
    idle(1);
    r0 = rdy_seen;
    feed_n(1'b0, 40);
    idle(2);
    chk("R9 master low gives no ready", rdy_seen - r0, 0);
    chk("R9 dout held with master low", int'(dout), d0);
    drain("R9");
  endtask

  task automatic pulse_sync();
    bit_vld = 1'b0;
    pwm_sync = 1'b1;
    @(posedge clk);
    #1;
    pwm_sync = 1'b0;
    m_clear();
  endtask

  task automatic t_pwm();
    int r0;
    cur_req = "R10";
    cfg_en = 1'b0; master_en = 1'b0;
    idle(1);
    sync_sel = 1'b1; cfg_kind = 2'd1; cfg_osr_m1 = 8'd3; cfg_wide = 1'b1;
    cfg_en = 1'b1;
    m_on = 0;
    r0 = rdy_seen;
    feed_n(1'b1, 20);
    idle(2);
    chk("R10 idle before first sync", rdy_seen - r0, 0);
    m_on = 1;
    pulse_sync();
    r0 = rdy_seen;
    feed_n(1'b1, 10);
    pulse_sync();
    feed_n(1'b1, 16);
    idle(2);
    chk("R10 sync realigns phase", rdy_seen - r0, 4);
    chk("R10 settled value after sync", $signed(dout), 16);
    drain("R10");
    cfg_en = 1'b0;
    idle(1);
  endtask

  initial begin
    m_clear();
    m_on = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_box();
    t_second();
    t_third_max();
    t_fast();
    t_narrow();
    t_mixed();
    t_unit();
    t_disable();
    t_pwm();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
    end
  end

endmodule